// File: doc/BRIEF.md
# Byte-Addressed Load/Store Unit

This unit connects a 32-bit register datapath to a data memory that is addressed by byte but stored as 32-bit words with per-byte write enables. Each request carries a base register value, a signed 16-bit byte offset, an access size (full word or single byte), a sign flag for byte loads, and store data. The unit adds the base and offset to form the effective address. It finds the byte lane that the address selects under the current byte-order setting. Stores merge into the addressed word. Loads come back extended to 32 bits.

A run-time input picks little-endian or big-endian lane numbering. A word access whose address is not a multiple of four is refused: memory is left unchanged and a one-cycle misalignment flag is raised. Byte accesses may use any address. A 256-word memory inside the unit makes it testable on its own. This memory is cleared by reset.

Top module: `lsu_top`

## Requirements
- R1: The effective address is `base` plus `offset` sign-extended from 16 bits. Only bits [9:2] of the effective address select the memory word, and higher bits are ignored.
- R2: A word store writes all 32 bits of `wdata`. A word load returns the stored word unchanged on `rsp_data`, with `rsp_valid` high in the cycle after the request.
- R3: A word access whose effective address has bits [1:0] not equal to 0 leaves memory unchanged. In the cycle after the request it raises `misalign` for one cycle and does not raise `rsp_valid`.
- R4: A byte load with `req_signed`=1 copies bit 7 of the loaded byte into bits [31:8] of `rsp_data`.
- R5: A byte load with `req_signed`=0 returns zeros in bits [31:8] of `rsp_data`.
- R6: A byte store writes only `wdata[7:0]` into one byte lane. Bits [31:8] of `wdata` are ignored, and the other three bytes of the word keep their values.
- R7: With `big_endian`=0, the byte at effective address with low bits k occupies bits [8k+7:8k] of its word.
- R8: With `big_endian`=1, the byte at low bits k occupies bits [8(3-k)+7:8(3-k)], so the lowest address holds the most significant byte.
- R9: Byte accesses never raise `misalign`, whatever the address.
- R10: After reset every memory word reads as 0.
- R11: A store takes effect at the clock edge that accepts it, so a load issued in the next cycle sees the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; also clears memory |
| big_endian | input | 1 | 1 selects big-endian lane numbering |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_signed | input | 1 | Byte loads: 1 = sign-extend, 0 = zero-extend |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed byte offset |
| wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Load data valid (one cycle after a load) |
| rsp_data | output | 32 | Extended load data |
| misalign | output | 1 | Refused misaligned word access, one cycle after request |

## Verification
A known word is written first, and then every byte address of it is loaded both signed and unsigned. A byte with bit 7 set and one with bit 7 clear show whether the sign fill comes from the right bit. The same sequence runs in both byte orders, which exposes a lane map that is swapped or stuck. Byte stores use data with nonzero upper bits at an interior address, so writing too wide and choosing the wrong lane give different results. Address forms include negative offsets, bases beyond the memory range, and misaligned word accesses, each followed by a read-back. These separate adder and wrap faults from write-suppression faults.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int XLEN  = 32;
  localparam int LANES = XLEN / 8;

  // Byte lane holding the byte at address low bits lo under the chosen order.
  function automatic logic [1:0] lane_of(input logic [1:0] lo, input logic big);
    return big ? ~lo : lo;
  endfunction

  // Widen one byte to a word, with or without sign fill.
  function automatic logic [XLEN-1:0] widen(input logic [7:0] b, input logic sgn);
    return {{(XLEN-8){sgn & b[7]}}, b};
  endfunction
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int XW    = 32,
  parameter int OFF_W = 16
) (
  input  logic [XW-1:0]    base,
  input  logic [OFF_W-1:0] offset,
  input  logic             word,
  output logic [XW-1:0]    ea,
  output logic             misal
);
  localparam int EXT_W = XW - OFF_W;
  assign ea    = base + {{EXT_W{offset[OFF_W-1]}}, offset};
  assign misal = word & (ea[1:0] != 2'b00);
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_pkg::*;
(
  input  logic [1:0]      ea_lo,
  input  logic            big,
  input  logic            word,
  input  logic [XLEN-1:0] wdata,
  output logic [LANES-1:0] be,
  output logic [XLEN-1:0] wword
);
  logic [1:0] lane;
  assign lane = lane_of(ea_lo, big);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign be[k]          = word | (lane == k[1:0]);
    assign wword[8*k +: 8] = word ? wdata[8*k +: 8] : wdata[7:0];
  end
endmodule

// File: rtl/lsu_mem.sv
module lsu_mem #(
  parameter int DEPTH = 256,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [LANES-1:0]   be,
  input  logic [IDX_W-1:0]   idx,
  input  logic [8*LANES-1:0] wword,
  input  logic               re,
  output logic [8*LANES-1:0] rdata
);
  logic [8*LANES-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rdata <= '0;
    end else begin
      if (we) begin
        for (int k = 0; k < LANES; k++)
          if (be[k]) mem[idx][8*k +: 8] <= wword[8*k +: 8];
      end
      if (re) rdata <= mem[idx];
    end
  end
endmodule

// File: rtl/lsu_top.sv
module lsu_top
  import lsu_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int OFF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             big_endian,
  input  logic             req_valid,
  input  logic             req_store,
  input  logic             req_word,
  input  logic             req_signed,
  input  logic [XLEN-1:0]  base,
  input  logic [OFF_W-1:0] offset,
  input  logic [XLEN-1:0]  wdata,
  output logic             rsp_valid,
  output logic [XLEN-1:0]  rsp_data,
  output logic             misalign
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int AW    = IDX_W + 2;

  // Named internal events
  logic [XLEN-1:0]  ea;
  logic [1:0]       ea_lo;
  logic             misal_now;
  logic             mem_we;
  logic [LANES-1:0] mem_be;
  logic [XLEN-1:0]  mem_wword;
  logic [XLEN-1:0]  mem_rdata;
  logic             load_go;
  logic             unused_ea_hi;

  lsu_agen #(.XW(XLEN), .OFF_W(OFF_W)) u_agen (
    .base(base), .offset(offset), .word(req_word), .ea(ea), .misal(misal_now)
  );

  assign ea_lo        = ea[1:0];
  assign unused_ea_hi = ^ea[XLEN-1:AW];

  lsu_store_lane u_lane (
    .ea_lo(ea_lo), .big(big_endian), .word(req_word), .wdata(wdata),
    .be(mem_be), .wword(mem_wword)
  );

  assign mem_we  = req_valid & req_store & ~misal_now;
  assign load_go = req_valid & ~req_store & ~misal_now;

  lsu_mem #(.DEPTH(DEPTH), .IDX_W(IDX_W), .LANES(LANES)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .be(mem_be),
    .idx(ea[AW-1:2]), .wword(mem_wword), .re(load_go), .rdata(mem_rdata)
  );

  // Response-side context, captured with the read
  logic [1:0] lane_q;
  logic       word_q, sgn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      misalign  <= 1'b0;
      lane_q    <= '0;
      word_q    <= 1'b0;
      sgn_q     <= 1'b0;
    end else begin
      rsp_valid <= load_go;
      misalign  <= req_valid & misal_now;
      if (load_go) begin
        lane_q <= lane_of(ea_lo, big_endian);
        word_q <= req_word;
        sgn_q  <= req_signed;
      end
    end
  end

  logic [7:0] sel_byte;
  always_comb begin
    sel_byte = mem_rdata[8*lane_q +: 8];
    rsp_data = word_q ? mem_rdata : widen(sel_byte, sgn_q);
  end
endmodule

// File: rtl/lsu_top_chk.sv
module lsu_top_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_store,
  input logic        req_word,
  input logic        req_signed,
  input logic        rsp_valid,
  input logic [31:0] rsp_data,
  input logic        misalign,
  input logic [1:0]  ea_lo,
  input logic        mem_we,
  input logic [3:0]  mem_be
);
  p_rsp_from_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_store));

  p_load_answers_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_store && !(req_word && ea_lo != 2'b00)) |=> rsp_valid);

  p_misal_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_word && ea_lo != 2'b00) |-> !mem_we);

  p_misal_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_word && ea_lo != 2'b00) |=> (misalign && !rsp_valid));

  p_sign_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(!req_word && req_signed)) |-> rsp_data[31:8] == {24{rsp_data[7]}});

  p_zero_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(!req_word && !req_signed)) |-> rsp_data[31:8] == 24'h0);

  p_one_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && !req_word) |-> (mem_we && $countones(mem_be) == 1));

  p_byte_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_word) |=> !misalign);
endmodule

bind lsu_top lsu_top_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
  .req_word(req_word), .req_signed(req_signed), .rsp_valid(rsp_valid),
  .rsp_data(rsp_data), .misalign(misalign), .ea_lo(ea_lo),
  .mem_we(mem_we), .mem_be(mem_be)
);

// File: tb/sim_lsu_top.sv
`timescale 1ns/1ps
module sim_lsu_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        big_endian = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_word = 1'b0, req_signed = 1'b0;
  logic [31:0] base = '0, wdata = '0;
  logic [15:0] offset = '0;
  logic        rsp_valid, misalign;
  logic [31:0] rsp_data;

  int nvec = 0, nerr = 0;
  logic        g_valid, g_mis;
  logic [31:0] g_data;

  always #2 clk = ~clk;

  lsu_top u0 (
    .clk(clk), .rst_n(rst_n), .big_endian(big_endian), .req_valid(req_valid),
    .req_store(req_store), .req_word(req_word), .req_signed(req_signed),
    .base(base), .offset(offset), .wdata(wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .misalign(misalign)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // Drive one request for one cycle; capture the response one cycle later.
  task automatic issue(input logic st, input logic wd, input logic sg,
                       input logic [31:0] b, input logic [15:0] off, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_word = wd; req_signed = sg;
    base = b; offset = off; wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    g_valid = rsp_valid; g_data = rsp_data; g_mis = misalign;
  endtask

  task automatic t_reset;
    issue(0, 1, 0, 32'h0, 16'h0, '0);
    chk("R10 word 0 after reset", g_data, 32'h0);
    chk("R2 rsp_valid on load", {31'b0, g_valid}, 32'h1);
    issue(0, 1, 0, 32'h3FC, 16'h0, '0);
    chk("R10 last word after reset", g_data, 32'h0);
    @(negedge clk);
    chk("R2 rsp_valid one cycle", {31'b0, rsp_valid}, 32'h0);
  endtask

  task automatic t_little;
    big_endian = 1'b0;
    issue(1, 1, 0, 32'h100, 16'h0, 32'h0000_0180);
    chk("R2 store gives no rsp", {31'b0, g_valid}, 32'h0);
    issue(0, 1, 0, 32'h100, 16'h0, '0);
    chk("R2 word readback", g_data, 32'h0000_0180);
    issue(0, 0, 1, 32'h100, 16'h1, '0);
    chk("R7 R4 signed byte A+1", g_data, 32'h0000_0001);
    issue(0, 0, 1, 32'h100, 16'h0, '0);
    chk("R4 signed byte A", g_data, 32'hFFFF_FF80);
    issue(0, 0, 0, 32'h100, 16'h0, '0);
    chk("R5 unsigned byte A", g_data, 32'h0000_0080);
    issue(1, 0, 0, 32'h100, 16'h2, 32'hFFFF_FF80);
    issue(0, 1, 0, 32'h100, 16'h0, '0);
    chk("R6 R7 byte store A+2", g_data, 32'h0080_0180);
  endtask

  task automatic t_big;
    big_endian = 1'b1;
    issue(1, 1, 0, 32'h200, 16'h0, 32'h1122_3344);
    issue(0, 0, 0, 32'h200, 16'h0, '0);
    chk("R8 BE byte A is msb", g_data, 32'h0000_0011);
    issue(0, 0, 1, 32'h203, 16'h0, '0);
    chk("R8 BE byte A+3 is lsb", g_data, 32'h0000_0044);
    chk("R9 odd byte no misalign", {31'b0, g_mis}, 32'h0);
    issue(1, 0, 0, 32'h200, 16'h1, 32'h1234_56AA);
    issue(0, 1, 0, 32'h200, 16'h0, '0);
    chk("R8 R6 BE byte store A+1", g_data, 32'h11AA_3344);
    issue(0, 0, 1, 32'h200, 16'h1, '0);
    chk("R4 R8 BE signed byte", g_data, 32'hFFFF_FFAA);
    big_endian = 1'b0;
  endtask

  task automatic t_misalign;
    issue(1, 1, 0, 32'h100, 16'h2, 32'hDEAD_BEEF);
    chk("R3 store misalign flag", {31'b0, g_mis}, 32'h1);
    @(negedge clk);
    chk("R3 flag one cycle", {31'b0, misalign}, 32'h0);
    issue(0, 1, 0, 32'h100, 16'h0, '0);
    chk("R3 memory unchanged", g_data, 32'h0080_0180);
    issue(0, 1, 0, 32'h101, 16'h0, '0);
    chk("R3 load misalign flag", {31'b0, g_mis}, 32'h1);
    chk("R3 no rsp_valid", {31'b0, g_valid}, 32'h0);
  endtask

  task automatic t_address;
    issue(1, 1, 0, 32'h108, 16'hFFFC, 32'hCAFE_F00D);
    issue(0, 1, 0, 32'h104, 16'h0, '0);
    chk("R1 negative offset store", g_data, 32'hCAFE_F00D);
    issue(0, 1, 0, 32'h0F0, 16'h0014, '0);
    chk("R1 positive offset load", g_data, 32'hCAFE_F00D);
    issue(0, 1, 0, 32'hFFFF_F500, 16'h0, '0);
    chk("R1 upper bits ignored", g_data, 32'h0080_0180);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    req_valid = 1'b1; req_store = 1'b1; req_word = 1'b1; req_signed = 1'b0;
    base = 32'h300; offset = 16'h0; wdata = 32'h5A5A_0001;
    @(negedge clk);
    req_store = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 load right after store", rsp_data, 32'h5A5A_0001);
    chk("R11 rsp_valid", {31'b0, rsp_valid}, 32'h1);
  endtask

  initial begin
    #400000;
    nerr++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle rsp_valid", {31'b0, rsp_valid}, 32'h0);
    chk("R3 idle misalign", {31'b0, misalign}, 32'h0);
    t_reset();
    t_little();
    t_big();
    t_misalign();
    t_address();
    t_back_to_back();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule